// File: doc/BRIEF.md
# Serial Byte Shifter with Acknowledge Slot

This block is the bit-level data path of a two-wire (I2C-style) bus controller. An 8-bit data register and a one-bit acknowledge flag form a single 9-bit shift register. Bus bits enter through the acknowledge flag on each sampled SCL rising edge and move toward the most significant bit. Outgoing bits pass through a separate one-bit output buffer, which updates on SCL falling edges. Transmitted bits are sampled back from SDA while they are sent. The data register therefore always ends a frame holding the byte that was actually on the bus, so a controller that loses arbitration already has the correct byte for the switch to slave receiver.

A frame-done flag tells the CPU side when the block owns nothing. While the flag is set, shifting stops and the data register stays frozen. The CPU may write a new byte only in that window, and it re-arms shifting by pulsing a clear strobe. An own-address register feeds a comparator that checks the first byte after a START and pulses a hit output. START/STOP detection, clock generation and the protocol state machine live outside the block. They drive the direction, master, START and acknowledge-value inputs.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `done_flag` is 1, `sda_out` is 1 (released), `cpu_rdata` is 0x00, `own_addr` is 0x00 and `addr_hit` is 0.
- R2: A `cpu_wr` pulse while `done_flag` is 0 is ignored: `cpu_rdata` keeps its value and the later frame result is unaffected.
- R3: A `cpu_wr` pulse while `done_flag` is 1 loads `cpu_rdata` with `cpu_wdata`, and `sda_out` shows `cpu_wdata[7]` from the next clock cycle.
- R4: Each `scl_rise` pulse while `done_flag` is 0 shifts {data, ack} left by one, with `sda_in` entering the ack position. After the ninth such pulse, the first bit received sits in data bit 7 (MSB first), the ninth bus bit is on `ack_bit`, and `done_flag` is 1 in the next cycle.
- R5: With `tx_mode`=1, each `scl_fall` after data rises 1 to 7 puts the next data bit on `sda_out`. The `scl_fall` after the eighth rise releases `sda_out` to 1 for the acknowledge slot.
- R6: After a transmit frame, `cpu_rdata` holds the bus bits sampled on `sda_in`, not the bits written. This holds even when the bus forced some bits low.
- R7: With `tx_mode`=0, `sda_out` stays 1 during the eight data bits. The `scl_fall` after the eighth rise drives `ack_value` onto `sda_out`.
- R8: While `done_flag` is 1, `scl_rise` and `scl_fall` pulses have no effect on `cpu_rdata`, `ack_bit` or `sda_out`.
- R9: A `flag_clr` pulse clears `done_flag` in the next cycle. In receive mode it also releases `sda_out` to 1.
- R10: When `master` is 0 and the eighth rise of the first byte after a `start_det` pulse completes a byte whose bits 7..1 equal `own_addr[7:1]`, `addr_hit` is 1 for exactly the one cycle after that rise.
- R11: A received byte of 0x00 raises `addr_hit` only when `own_addr[0]` (general-call enable) is 1.
- R12: When `master` is 1, the address comparison is ignored and `addr_hit` stays 0.
- R13: Only the first byte after `start_det` is compared. A matching second byte in the same transfer gives no `addr_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Data register write value |
| cpu_rdata | output | 8 | Data register contents |
| adr_wr | input | 1 | Own-address register write strobe |
| adr_wdata | input | 8 | Own-address value: bits 7..1 address, bit 0 general-call enable |
| own_addr | output | 8 | Own-address register contents |
| flag_clr | input | 1 | Clears the frame-done flag and re-arms shifting |
| done_flag | output | 1 | Frame-done flag; 1 while the block is not shifting |
| scl_rise | input | 1 | One-cycle strobe for a sampled SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe for a sampled SCL falling edge |
| sda_in | input | 1 | Sampled SDA level |
| sda_out | output | 1 | SDA drive level from the output buffer (1 = released) |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| ack_value | input | 1 | Level driven in the acknowledge slot in receive mode |
| master | input | 1 | 1 = master mode, address comparison disabled |
| start_det | input | 1 | START seen: restart bit count and arm the address compare |
| ack_bit | output | 1 | Acknowledge flag, the ninth bit of the last frame |
| addr_hit | output | 1 | One-cycle own-address or general-call match pulse |

## Verification
Every result comes from exactly one register, so it is due one clock after the edge that takes the strobe. The data register and `sda_out` follow a `cpu_wr`, `scl_rise` or `scl_fall`. `done_flag` follows the ninth rise or a clear. `addr_hit` follows the eighth rise. Each strobe is raised at a falling clock edge and dropped at the next falling edge. The bench samples outputs at that second falling edge, half a period after the register updated. `addr_hit` is sampled there for the eighth rise of every frame. A separate falling-edge counter of `addr_hit` cycles confirms that each match is a single-cycle pulse and that non-matching frames produce none.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } dir_e;

   // width of a counter that must hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/i2cs_frame_ctr.sv
`timescale 1ns/1ps
module i2cs_frame_ctr
   import i2cs_pkg::*;
#(
   parameter int unsigned DW = 8,
   localparam int unsigned CW = cnt_width(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          flag_clr,
   input  logic          start_det,
   output logic [CW-1:0] bit_cnt,
   output logic          idle,
   output logic          first_byte,
   output logic          data_end
);

   localparam logic [CW-1:0] LAST = CW'(DW);
   localparam logic [CW-1:0] LAST_DATA = CW'(DW - 1);

   logic shift_en;

   assign shift_en = scl_rise && !idle;
   assign data_end = shift_en && (bit_cnt == LAST_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         idle       <= 1'b1;
         first_byte <= 1'b0;
      end else begin
         if (start_det) begin
            bit_cnt    <= '0;
            first_byte <= 1'b1;
         end else begin
            if (shift_en) begin
               if (bit_cnt == LAST) bit_cnt <= '0;
               else                 bit_cnt <= bit_cnt + 1'b1;
            end
            if (data_end) first_byte <= 1'b0;
         end
         if (flag_clr)
            idle <= 1'b0;
         else if (shift_en && bit_cnt == LAST)
            idle <= 1'b1;
      end
   end

   // R4: the counter never passes the acknowledge slot
   p_cnt_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= LAST);

   // R4: the frame-done flag only rises right after an SCL rising edge
   p_flag_after_rise_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> $past(scl_rise));

   // R9: a clear strobe always drops the flag
   p_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !idle);

endmodule

// File: rtl/i2cs_shift_core.sv
`timescale 1ns/1ps
module i2cs_shift_core
   import i2cs_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_in,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   input  dir_e          dir,
   input  logic          ack_value,
   input  logic          ack_slot,
   input  logic          flag_clr,
   output logic [DW-1:0] dat_q,
   output logic          ack_q,
   output logic          obuf_q
);

   logic wr_ok;
   logic rise_ok;
   logic fall_ok;
   logic fall_val;

   assign wr_ok   = cpu_wr && idle;
   assign rise_ok = scl_rise && !idle;
   assign fall_ok = scl_fall && !idle;

   always_comb begin
      if (ack_slot) fall_val = (dir == DIR_TX) ? 1'b1 : ack_value;
      else          fall_val = (dir == DIR_TX) ? dat_q[DW-1] : 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q  <= '0;
         ack_q  <= 1'b1;
         obuf_q <= 1'b1;
      end else begin
         if (wr_ok) begin
            dat_q  <= cpu_wdata;
            obuf_q <= cpu_wdata[DW-1];
         end else begin
            if (rise_ok)
               {dat_q, ack_q} <= {dat_q[DW-2:0], ack_q, sda_in};
            if (fall_ok)
               obuf_q <= fall_val;
            else if (flag_clr && idle && dir == DIR_RX)
               obuf_q <= 1'b1;
         end
      end
   end

   // R8: a frozen register keeps data and ack unless the CPU writes
   p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !cpu_wr) |=> ($stable(dat_q) && $stable(ack_q)));

   // R3: a CPU write presents the new MSB on the bus buffer
   p_load_msb_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (obuf_q == $past(cpu_wdata[DW-1])));

   // R7: a receiver keeps SDA released during the data bits
   p_rx_release_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fall_ok && !ack_slot && dir == DIR_RX) |=> obuf_q);

   // R5: a transmitter releases SDA for the acknowledge slot
   p_tx_ack_release_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fall_ok && ack_slot && dir == DIR_TX) |=> obuf_q);

endmodule

// File: rtl/i2cs_addr_match.sv
`timescale 1ns/1ps
module i2cs_addr_match
   import i2cs_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter bit          GCALL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adr_wr,
   input  logic [DW-1:0] adr_wdata,
   input  logic          sample,
   input  logic [DW-2:0] rx_upper,
   input  logic          rx_lsb,
   output logic [DW-1:0] own_q,
   output logic          hit_q
);

   logic addr_eq;
   logic gc_eq;

   assign addr_eq = (rx_upper == own_q[DW-1:1]);

   generate
      if (GCALL_EN) begin : g_gcall
         assign gc_eq = own_q[0] && (rx_upper == '0) && !rx_lsb;
      end else begin : g_no_gcall
         assign gc_eq = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q <= '0;
         hit_q <= 1'b0;
      end else begin
         if (adr_wr) own_q <= adr_wdata;
         hit_q <= sample && (addr_eq || gc_eq);
      end
   end

   // R10: a match is a single-cycle pulse
   p_hit_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |=> !hit_q);

   // R12: a match needs a sampled first byte
   p_hit_needs_sample_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(sample));

endmodule

// File: rtl/i2c_byte_shifter.sv
`timescale 1ns/1ps
module i2c_byte_shifter
   import i2cs_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter bit          GCALL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic          adr_wr,
   input  logic [DW-1:0] adr_wdata,
   output logic [DW-1:0] own_addr,
   input  logic          flag_clr,
   output logic          done_flag,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_in,
   output logic          sda_out,
   input  logic          tx_mode,
   input  logic          ack_value,
   input  logic          master,
   input  logic          start_det,
   output logic          ack_bit,
   output logic          addr_hit
);

   localparam int unsigned CW = cnt_width(DW);

   if (DW < 4) begin : g_bad_width
      $error("i2c_byte_shifter: DW must be at least 4");
   end

   logic [CW-1:0] bit_cnt;
   logic          idle;
   logic          first_byte;
   logic          data_end;
   logic          ack_slot;
   logic [DW-1:0] dat_q;
   logic          ack_q;
   logic          cmp_sample;
   dir_e          dir;

   assign dir      = tx_mode ? DIR_TX : DIR_RX;
   assign ack_slot = (bit_cnt == CW'(DW));

   i2cs_frame_ctr #(.DW(DW)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .flag_clr   (flag_clr),
      .start_det  (start_det),
      .bit_cnt    (bit_cnt),
      .idle       (idle),
      .first_byte (first_byte),
      .data_end   (data_end)
   );

   i2cs_shift_core #(.DW(DW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_in    (sda_in),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .dir       (dir),
      .ack_value (ack_value),
      .ack_slot  (ack_slot),
      .flag_clr  (flag_clr),
      .dat_q     (dat_q),
      .ack_q     (ack_q),
      .obuf_q    (sda_out)
   );

   assign cmp_sample = data_end && first_byte && !master && !start_det;

   i2cs_addr_match #(.DW(DW), .GCALL_EN(GCALL_EN)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .adr_wr    (adr_wr),
      .adr_wdata (adr_wdata),
      .sample    (cmp_sample),
      .rx_upper  ({dat_q[DW-3:0], ack_q}),
      .rx_lsb    (sda_in),
      .own_q     (own_addr),
      .hit_q     (addr_hit)
   );

   assign cpu_rdata = dat_q;
   assign done_flag = idle;
   assign ack_bit   = ack_q;

   // R12: master mode never reports a slave address match
   p_master_quiet_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(master) |-> !addr_hit);

endmodule

// File: tb/test_i2c_byte_shifter.sv
`timescale 1ns/1ps
module test_i2c_byte_shifter;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_wr, adr_wr, flag_clr, scl_rise, scl_fall, sda_in;
   logic          tx_mode, ack_value, master, start_det;
   logic [DW-1:0] cpu_wdata, adr_wdata;
   logic [DW-1:0] cpu_rdata, own_addr;
   logic          done_flag, sda_out, ack_bit, addr_hit;

   int n_chk = 0;
   int n_bad = 0;
   int hit_total = 0;

   always #4 clk = ~clk;

   i2c_byte_shifter #(.DW(DW)) i_i2c_byte_shifter (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .adr_wr(adr_wr), .adr_wdata(adr_wdata), .own_addr(own_addr),
      .flag_clr(flag_clr), .done_flag(done_flag),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .sda_out(sda_out),
      .tx_mode(tx_mode), .ack_value(ack_value), .master(master),
      .start_det(start_det), .ack_bit(ack_bit), .addr_hit(addr_hit)
   );

   always @(negedge clk) if (rst_n && addr_hit) hit_total++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_data(input logic [DW-1:0] v);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic wr_addr(input logic [DW-1:0] v);
      @(negedge clk); adr_wr = 1'b1; adr_wdata = v;
      @(negedge clk); adr_wr = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic start_pulse();
      @(negedge clk); start_det = 1'b1;
      @(negedge clk); start_det = 1'b0;
   endtask

   task automatic rise(output logic hit);
      @(negedge clk); scl_rise = 1'b1;
      @(negedge clk); scl_rise = 1'b0; hit = addr_hit;
   endtask

   task automatic fall();
      @(negedge clk); scl_fall = 1'b1;
      @(negedge clk); scl_fall = 1'b0;
   endtask

   // nine bus bits; the bus is a wired AND of drv and the block's output
   task automatic frame(input logic [8:0] drv, output logic [8:0] seen, output logic hit8);
      logic h;
      hit8 = 1'b0;
      for (int i = 0; i < 9; i++) begin
         seen[8-i] = sda_out;
         sda_in = drv[8-i] & sda_out;
         rise(h);
         if (i == 7) hit8 = h;
         if (i < 8) fall();
      end
   endtask

   task automatic t_reset();
      chk("R1 flag", done_flag, 1);
      chk("R1 sda_out", sda_out, 1);
      chk("R1 rdata", cpu_rdata, 0);
      chk("R1 own_addr", own_addr, 0);
      chk("R1 addr_hit", addr_hit, 0);
   endtask

   task automatic t_tx();
      logic [8:0] seen; logic h;
      master = 1'b1; tx_mode = 1'b1;
      wr_data(8'h35);
      chk("R3 msb0", sda_out, 0);
      chk("R3 rdata", cpu_rdata, 8'h35);
      wr_data(8'hA5);
      chk("R3 msb1", sda_out, 1);
      clr_flag();
      chk("R9 cleared", done_flag, 0);
      frame(9'h1FE, seen, h);
      chk("R5 bits on sda_out", seen, {8'hA5, 1'b1});
      chk("R6 loopback", cpu_rdata, 8'hA5);
      chk("R4 ack", ack_bit, 0);
      chk("R4 flag set", done_flag, 1);
   endtask

   task automatic t_arb();
      logic [8:0] seen; logic h;
      wr_data(8'hFF);
      clr_flag();
      frame({8'h3C, 1'b1}, seen, h);
      chk("R6 bus bits kept", cpu_rdata, 8'h3C);
      chk("R4 nack", ack_bit, 1);
   endtask

   task automatic t_rx();
      logic [8:0] seen; logic h;
      master = 1'b0; tx_mode = 1'b0; ack_value = 1'b0;
      clr_flag();
      chk("R9 release", sda_out, 1);
      frame({8'h96, 1'b1}, seen, h);
      chk("R7 rx drive", seen, {8'hFF, 1'b0});
      chk("R4 msb first", cpu_rdata, 8'h96);
      chk("R4 ack own", ack_bit, 0);
      chk("R4 flag", done_flag, 1);
      chk("R13 no start no hit", h, 0);
   endtask

   task automatic t_wr_busy();
      logic [8:0] seen; logic h;
      clr_flag();
      wr_data(8'h11);
      chk("R2 busy write ignored", cpu_rdata, 8'h96);
      chk("R2 sda_out", sda_out, 1);
      frame({8'h3B, 1'b1}, seen, h);
      chk("R2 frame result", cpu_rdata, 8'h3B);
   endtask

   task automatic t_hold();
      logic h;
      logic [7:0] d0; logic a0, s0;
      d0 = cpu_rdata; a0 = ack_bit; s0 = sda_out;
      sda_in = ~a0;
      rise(h);
      fall();
      rise(h);
      chk("R8 data frozen", cpu_rdata, d0);
      chk("R8 ack frozen", ack_bit, a0);
      chk("R8 sda_out frozen", sda_out, s0);
      chk("R8 flag", done_flag, 1);
   endtask

   task automatic t_addr();
      logic [8:0] seen; logic h; int base;
      wr_addr(8'h5A);
      chk("R10 own_addr", own_addr, 8'h5A);
      base = hit_total;
      start_pulse(); clr_flag();
      frame({8'h5B, 1'b1}, seen, h);
      chk("R10 match", h, 1);
      chk("R10 one cycle", hit_total - base, 1);
      base = hit_total;
      clr_flag();
      frame({8'h5B, 1'b1}, seen, h);
      chk("R13 second byte", h, 0);
      start_pulse(); clr_flag();
      frame({8'h5C, 1'b1}, seen, h);
      chk("R10 mismatch", h, 0);
      chk("R13 R10 no pulses", hit_total - base, 0);
   endtask

   task automatic t_gcall();
      logic [8:0] seen; logic h; int base;
      wr_addr(8'h5B);
      base = hit_total;
      start_pulse(); clr_flag();
      frame({8'h00, 1'b1}, seen, h);
      chk("R11 gc on", h, 1);
      wr_addr(8'h5A);
      start_pulse(); clr_flag();
      frame({8'h00, 1'b1}, seen, h);
      chk("R11 gc off", h, 0);
      chk("R11 pulse count", hit_total - base, 1);
   endtask

   task automatic t_master();
      logic [8:0] seen; logic h; int base;
      master = 1'b1;
      base = hit_total;
      start_pulse(); clr_flag();
      frame({8'h5B, 1'b1}, seen, h);
      chk("R12 master no hit", h, 0);
      chk("R12 no pulses", hit_total - base, 0);
      master = 1'b0;
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cpu_wr = 0; adr_wr = 0; flag_clr = 0; scl_rise = 0; scl_fall = 0; sda_in = 1;
      tx_mode = 0; ack_value = 1; master = 0; start_det = 0;
      cpu_wdata = '0; adr_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx();
      t_arb();
      t_rx();
      t_wr_busy();
      t_hold();
      t_addr();
      t_gcall();
      t_master();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule